// File: doc/BRIEF.md
# Sparse Hybrid Prefix Binary Adder

This block is a purely combinational binary adder of parameterised width. It adds two unsigned operands and a carry-in, and returns the sum and the carry-out. The default width is 24 bits. The same module is meant to be instantiated at 6, 12 and 48 bits in the merge stages of a partial-product multiplier, and it also accepts other widths, odd ones included.

The adder works in three phases. First, each bit position forms its own propagate and generate signals, and the carry-in is folded into position 0. Second, a prefix tree builds the group generate of every bit position down to bit 0. Third, each sum bit is formed from its propagate and the carry into that position. The tree is sparse. An opening level pairs each odd position with the even position just below it. A series of doubling-span levels then runs on the odd positions only. A closing level completes each even position from the finished odd prefix next to it.

Top module: `hca_adder`

## Requirements
- R1: {cout_o, sum_o} equals a_i + b_i + cin_i, computed at WIDTH+1 bits, for every operand pair at the default width of 24.
- R2: When b_i is the bitwise complement of a_i, so that every position propagates, a carry-in of 0 gives sum_o all ones and cout_o 0. A carry-in of 1 gives sum_o all zeros and cout_o 1.
- R3: All-ones plus one with cin_i 0, or all-ones plus zero with cin_i 1, wraps to sum_o 0 with cout_o 1.
- R4: For fixed operands, raising cin_i from 0 to 1 increases the (WIDTH+1)-bit result {cout_o, sum_o} by exactly one.
- R5: With b_i zero and cin_i 0, sum_o equals a_i and cout_o is 0.
- R6: R1 holds at widths 6, 12 and 48, the widths the multiplier merge stages use.
- R7: R1 holds at an odd width (5), where some tree nodes have no partner and pass their value through unchanged.
- R8: Swapping a_i and b_i leaves sum_o and cout_o unchanged.
- R9: When cout_o is 1 and cin_i is 0, sum_o is strictly less than a_i, because the result has wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The carry-in injection and the longest propagate chain can both act on the same evaluation. In that case a carry entering at bit 0 must travel through every position to the carry-out, passing both the opening and the closing sparse levels. The bench provokes this by driving complementary operands and all-ones-plus-one patterns with cin_i at both values, and by pairing each random vector with its carry-in-raised twin. Each result is judged against sums the bench computes itself at full width. Exhaustive sweeps at widths 6 and 5 cover every operand pair, so every pass-through node in the tree is exercised.

// File: rtl/hca_pkg.sv
package hca_pkg;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // hi covers higher bits, lo the adjacent lower group
  function automatic pg_t pg_merge(pg_t hi, pg_t lo);
    pg_t r;
    r.p = hi.p & lo.p;
    r.g = hi.g | (hi.p & lo.g);
    return r;
  endfunction

  // doubling-span levels on odd positions after the opening pair level
  function automatic int unsigned ks_levels(int unsigned w);
    if (w <= 2) return 0;
    return $clog2(w) - 1;
  endfunction

endpackage

// File: rtl/hca_pg_gen.sv
module hca_pg_gen
  import hca_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] prop_o,
  output pg_t  [WIDTH-1:0] pg_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    assign prop_o[i] = a_i[i] ^ b_i[i];
    assign pg_o[i].p = a_i[i] ^ b_i[i];
    if (i == 0) begin : gen_cin
      // carry-in folded in as generate of position 0
      assign pg_o[i].g = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cin_i);
    end else begin : gen_plain
      assign pg_o[i].g = a_i[i] & b_i[i];
    end
  end

endmodule

// File: rtl/hca_prefix_tree.sv
module hca_prefix_tree
  import hca_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  pg_t  [WIDTH-1:0] pg_i,
  output logic [WIDTH-1:0] grp_o
);

  localparam int unsigned KS = ks_levels(WIDTH);

  pg_t [KS:0][WIDTH-1:0] net;
  pg_t [WIDTH-1:0]       fin;

  // opening sparse level: odd position absorbs its even neighbour
  for (genvar i = 0; i < WIDTH; i++) begin : gen_open
    if (i % 2 == 1) begin : gen_odd
      assign net[0][i] = pg_merge(pg_i[i], pg_i[i-1]);
    end else begin : gen_even
      assign net[0][i] = pg_i[i];
    end
  end

  // dense levels restricted to odd positions, span 2,4,8,...
  for (genvar k = 1; k <= KS; k++) begin : gen_lvl
    localparam int unsigned SPAN = 2 ** k;
    for (genvar i = 0; i < WIDTH; i++) begin : gen_node
      if ((i % 2 == 1) && (i >= SPAN)) begin : gen_op
        assign net[k][i] = pg_merge(net[k-1][i], net[k-1][i-SPAN]);
      end else begin : gen_pass
        assign net[k][i] = net[k-1][i];
      end
    end
  end

  // closing sparse level: even position completes from odd prefix below
  for (genvar i = 0; i < WIDTH; i++) begin : gen_close
    if (i == 0) begin : gen_lsb
      assign fin[i] = pg_i[i];
    end else if (i % 2 == 0) begin : gen_even
      assign fin[i] = pg_merge(pg_i[i], net[KS][i-1]);
    end else begin : gen_odd
      assign fin[i] = net[KS][i];
    end
    assign grp_o[i] = fin[i].g;
  end

endmodule

// File: rtl/hca_sum_gen.sv
module hca_sum_gen #(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] grp_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] carry;

  for (genvar i = 0; i < WIDTH; i++) begin : gen_sum
    if (i == 0) begin : gen_lsb
      assign carry[i] = cin_i;
    end else begin : gen_up
      assign carry[i] = grp_i[i-1];
    end
    assign sum_o[i] = prop_i[i] ^ carry[i];
  end

  assign cout_o = grp_i[WIDTH-1];

endmodule

// File: rtl/hca_adder.sv
module hca_adder
  import hca_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] prop;
  pg_t  [WIDTH-1:0] pg;
  logic [WIDTH-1:0] grp;

  hca_pg_gen #(.WIDTH(WIDTH)) i_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .prop_o (prop),
    .pg_o   (pg)
  );

  hca_prefix_tree #(.WIDTH(WIDTH)) i_tree (
    .pg_i  (pg),
    .grp_o (grp)
  );

  hca_sum_gen #(.WIDTH(WIDTH)) i_sum (
    .prop_i (prop),
    .grp_i  (grp),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

endmodule

// File: rtl/hca_adder_chk.sv
module hca_adder_chk #(
  parameter int unsigned WIDTH = 24
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_i,
  input logic             cout_i
);

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_EXACT: assert ({cout_i, sum_i} == ref_sum); // R1
    if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
      AST_PROP_CHAIN: assert ({cout_i, sum_i} == {cin_i, {WIDTH{~cin_i}}}); // R2
    end
    if ((b_i == '0) && !cin_i) begin
      AST_ZERO_OPERAND: assert ((sum_i == a_i) && !cout_i); // R5
    end
    if (cout_i && !cin_i) begin
      AST_WRAP_LOWER: assert (sum_i < a_i); // R9
    end
  end

endmodule

bind hca_adder hca_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_i  (sum_o),
  .cout_i (cout_o)
);

// File: tb/test_hca_adder.sv
module test_hca_adder;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [23:0] a24 = '0, b24 = '0, s24;
  logic        c24 = 1'b0, co24;
  logic [5:0]  a6 = '0, b6 = '0, s6;
  logic        c6 = 1'b0, co6;
  logic [4:0]  a5 = '0, b5 = '0, s5;
  logic        c5 = 1'b0, co5;
  logic [11:0] a12 = '0, b12 = '0, s12;
  logic        c12 = 1'b0, co12;
  logic [47:0] a48 = '0, b48 = '0, s48;
  logic        c48 = 1'b0, co48;

  hca_adder i_hca_adder (.a_i(a24), .b_i(b24), .cin_i(c24), .sum_o(s24), .cout_o(co24));
  hca_adder #(.WIDTH(6))  i_hca_adder_w6  (.a_i(a6),  .b_i(b6),  .cin_i(c6),  .sum_o(s6),  .cout_o(co6));
  hca_adder #(.WIDTH(5))  i_hca_adder_w5  (.a_i(a5),  .b_i(b5),  .cin_i(c5),  .sum_o(s5),  .cout_o(co5));
  hca_adder #(.WIDTH(12)) i_hca_adder_w12 (.a_i(a12), .b_i(b12), .cin_i(c12), .sum_o(s12), .cout_o(co12));
  hca_adder #(.WIDTH(48)) i_hca_adder_w48 (.a_i(a48), .b_i(b48), .cin_i(c48), .sum_o(s48), .cout_o(co48));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive24(input logic [23:0] a, input logic [23:0] b, input logic c);
    @(posedge clk);
    a24 = a; b24 = b; c24 = c;
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp24(input logic [23:0] a, input logic [23:0] b, input logic c);
    return 64'(a) + 64'(b) + 64'(c);
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] r0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check("R5 reset idle", 64'({co24, s24}), 64'd0);

    // corner patterns
    drive24(24'hFFFFFF, 24'd1, 1'b0);
    check("R3 ones+1", 64'({co24, s24}), 64'h1000000);
    drive24(24'hFFFFFF, 24'd0, 1'b1);
    check("R3 ones+cin", 64'({co24, s24}), 64'h1000000);
    drive24(24'hA5C3F0, 24'h5A3C0F, 1'b0);
    check("R2 chain cin0", 64'({co24, s24}), 64'h0FFFFFF);
    drive24(24'hA5C3F0, 24'h5A3C0F, 1'b1);
    check("R2 chain cin1", 64'({co24, s24}), 64'h1000000);
    drive24(24'h000000, 24'hFFFFFF, 1'b1);
    check("R2 chain zero", 64'({co24, s24}), 64'h1000000);
    drive24(24'h123456, 24'd0, 1'b0);
    check("R5 zero b", 64'({co24, s24}), 64'h123456);
    drive24(24'hFFFFFF, 24'hFFFFFF, 1'b1);
    check("R1 max", 64'({co24, s24}), exp24(24'hFFFFFF, 24'hFFFFFF, 1'b1));

    for (int n = 0; n < 600; n++) begin
      logic [23:0] ra, rb;
      ra = 24'($urandom);
      rb = 24'($urandom);
      if (n % 8 == 0) rb = ~ra ^ (24'd1 << (n % 24));
      drive24(ra, rb, 1'b0);
      r0 = 64'({co24, s24});
      check("R1 random", r0, exp24(ra, rb, 1'b0));
      if (co24) check("R9 wrap", 64'(s24 < ra), 64'd1);
      drive24(rb, ra, 1'b0);
      check("R8 swap", 64'({co24, s24}), r0);
      drive24(ra, rb, 1'b1);
      check("R4 cin step", 64'({co24, s24}), (r0 + 64'd1) & 64'h1FFFFFF);
    end

    // exhaustive 6-bit
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a6 = 6'(x); b6 = 6'(y); c6 = 1'(c);
          @(negedge clk);
          check("R6 w6", 64'({co6, s6}), 64'(x + y + c));
        end
      end
    end

    // exhaustive odd width 5
    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a5 = 5'(x); b5 = 5'(y); c5 = 1'(c);
          @(negedge clk);
          check("R7 w5", 64'({co5, s5}), 64'(x + y + c));
        end
      end
    end

    for (int n = 0; n < 400; n++) begin
      logic [11:0] ra, rb;
      logic        rc;
      ra = 12'($urandom); rb = 12'($urandom); rc = 1'($urandom);
      if (n == 0) begin ra = 12'hFFF; rb = 12'h000; rc = 1'b1; end
      @(posedge clk);
      a12 = ra; b12 = rb; c12 = rc;
      @(negedge clk);
      check("R6 w12", 64'({co12, s12}), 64'(ra) + 64'(rb) + 64'(rc));
    end

    for (int n = 0; n < 400; n++) begin
      logic [47:0] ra, rb;
      logic        rc;
      ra = {16'($urandom), 32'($urandom)};
      rb = {16'($urandom), 32'($urandom)};
      rc = 1'($urandom);
      if (n == 0) begin ra = '1; rb = '0; rc = 1'b1; end
      if (n == 1) begin rb = ~ra; rc = 1'b1; end
      @(posedge clk);
      a48 = ra; b48 = rb; c48 = rc;
      @(negedge clk);
      check("R6 w48", 64'({co48, s48}), 64'(ra) + 64'(rb) + 64'(rc));
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule